// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master/Slave, Fault Detecting)

This block is a one-byte SPI engine that a processor reaches through three small registers: control, status and data. A module-select strobe and a two-bit address pick the register. As master it builds SCK from the bus clock, shifts the data byte out on MOSI and collects the reply from MISO. As slave it follows SS, SCK and MOSI and drives MISO. Clock polarity and phase are programmable. Both ends of a link must use the same setting.

Two faults are detected. A data write that arrives during a transfer sets a collision flag and leaves the byte in flight untouched. An external SS assertion seen while this port is master means another master is on the bus. The port then gives up mastership, turns itself off so that every pin becomes an input, and raises a mode-fault flag. The interrupt line reports that fault and also the end of each transfer.

Register layout. Control is at address 0 and is read/write: bit 7 interrupt enable, bit 6 port enable, bit 5 spare (stored and read back), bit 4 master, bit 3 CPOL, bit 2 CPHA, bits 1:0 rate. Status is at address 1 and is read-only: bit 7 transfer done, bit 6 write collision, bit 4 mode fault, other bits zero. Data is at address 2: a write loads the byte to send, and a read returns the last received byte. Address 3 reads as zero.

Top module: `spi_port`

## Requirements
- R1: As master, SCK holds each level for 1, 2, 8 or 16 bus cycles for rate codes 00, 01, 10 and 11 (the bus clock divided by 2, 4, 16 and 32).
- R2: As master, a data write while idle starts a transfer. The byte goes out MSB first on MOSI and the reply is shifted in from MISO. After 16 SCK edges the done flag (status bit 7) sets and a data read returns the received byte.
- R3: With the master idle, SCK rests at CPOL, including after a transfer. With CPHA=0 the first bit is valid before the first edge and data is sampled on leading edges. With CPHA=1 data changes on leading edges and is sampled on trailing edges.
- R4: As slave, a byte completes only if SS stays low across all 16 SCK edges. If SS rises earlier, the transfer is dropped: done stays clear and the data read value is unchanged.
- R5: As slave with CPHA=0, SS going low drives bit 7 of the loaded byte onto MISO before any SCK edge. The whole loaded byte is returned MSB first.
- R6: As slave during an active transfer, a data read returns the previous received byte. A data write sets the collision flag and does not change the byte going out on MISO.
- R7: As master, a data write during a transfer sets the collision flag (status bit 6). The byte in flight on MOSI is unchanged.
- R8: MISO output enable is high only when the port is an enabled slave and SS is low. A deselected slave ignores SCK and MOSI. As master, SCK and MOSI are driven and MISO is not.
- R9: With SS low while the port is an enabled master, the master and enable bits clear, all three output enables drop and the mode-fault flag (status bit 4) sets.
- R10: The interrupt line is high when interrupt enable is set and either the done flag or the mode-fault flag is set.
- R11: A status read followed by a data read or write clears done and collision. A status read followed by a control write clears mode fault. Without the status read first, the flag stays set.
- R12: Reset clears control and status. Control reads back all eight written bits. Address 3 reads zero. Accesses without module select have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Module select for register access |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while sel and rd_en are high |
| irq | output | 1 | Interrupt request |
| ss_n | input | 1 | Slave select, active low |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data input (slave) |
| mosi_o | output | 1 | Master-out data output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in data input (master) |
| miso_o | output | 1 | Master-in data output (slave) |
| miso_oe | output | 1 | Master-in output enable |

## Verification
The hardest cases to reach are the collisions in the middle of a transfer. The CPU side has to access the data register while the serial side is partway through a byte, and in slave mode that moment depends on external SCK edges passing through the input synchronizers. The bench plays the far end of the link at the pin level. It toggles SCK slowly enough to know when each edge has been taken. At a chosen edge count it interleaves a data read and a data write, then confirms at the pins that the outgoing byte still arrives intact, that the collision flag is set, and that the read returned the earlier byte. Mode faults and early SS release are driven the same way, from the pins.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int HALF_W  = 4;
    localparam int SYNC_N  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       spare;
        logic       mstr;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
    } flags_t;

    // Terminal count of the half-period counter: half period minus one.
    function automatic logic [HALF_W-1:0] half_limit(input logic [1:0] rate);
        case (rate)
            2'd0:    half_limit = HALF_W'(0);
            2'd1:    half_limit = HALF_W'(1);
            2'd2:    half_limit = HALF_W'(7);
            default: half_limit = HALF_W'(15);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input flags_t f);
        stat_word = {f.done, f.wcol, 1'b0, f.modf, 4'b0000};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    st[i] <= RST_V;
                else if (i == 0)
                    st[i] <= d;
                else
                    st[i] <= st[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] lim,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          step,
    input  logic          cpha,
    input  logic          bit_in,
    input  logic [DW-1:0] load,
    output logic          busy,
    output logic          done,
    output logic          lvl,
    output logic          bit_out,
    output logic [DW-1:0] rx_word
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0] ecnt;
    logic [DW-1:0] tx_sr, rx_sr, rx_nxt;
    logic          samp, last;

    always_comb begin
        // Even edge count = leading edge; sampling edge is leading when CPHA=0.
        samp   = ~ecnt[0] ^ cpha;
        last   = (ecnt == EW'(EDGES - 1));
        rx_nxt = samp ? {rx_sr[DW-2:0], bit_in} : rx_sr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            lvl     <= 1'b0;
            bit_out <= 1'b0;
            ecnt    <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                lvl  <= 1'b0;
                ecnt <= '0;
            end else if (start && !busy) begin
                busy <= 1'b1;
                lvl  <= 1'b0;
                ecnt <= '0;
                if (!cpha) begin
                    bit_out <= load[DW-1];
                    tx_sr   <= {load[DW-2:0], 1'b0};
                end else begin
                    tx_sr   <= load;
                end
            end else if (busy && step) begin
                lvl   <= ~lvl;
                ecnt  <= ecnt + 1'b1;
                rx_sr <= rx_nxt;
                if (!samp) begin
                    bit_out <= tx_sr[DW-1];
                    tx_sr   <= {tx_sr[DW-2:0], 1'b0};
                end
                if (last) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_word <= rx_nxt;
                    ecnt    <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq,
    input  logic        ss_n,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    input  logic        mosi_i,
    output logic        mosi_o,
    output logic        mosi_oe,
    input  logic        miso_i,
    output logic        miso_o,
    output logic        miso_oe
);
    ctrl_t             ctl_q;
    flags_t            flg_q;
    logic              arm_data_q, arm_ctl_q;
    logic [DATA_W-1:0] tx_buf_q, rx_buf_q;

    logic ss_s, sck_s, mosi_s, sck_d, ss_d;
    logic wr_ctrl, rd_stat, acc_data, wr_data;
    logic is_master, is_slave, fault;
    logic m_start, s_start, eng_start, eng_abort, eng_step, eng_bit_in;
    logic busy, done, lvl, bit_out, tick;
    logic [DATA_W-1:0] eng_load, rx_word;

    spi_sync #(.W(3), .STAGES(SYNC_N), .RST_V(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n, sck_i, mosi_i}),
        .q   ({ss_s, sck_s, mosi_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_s;
        end
    end

    always_comb begin
        wr_ctrl   = sel && wr_en && (addr == A_CTRL);
        rd_stat   = sel && rd_en && (addr == A_STAT);
        acc_data  = sel && (rd_en || wr_en) && (addr == A_DATA);
        wr_data   = sel && wr_en && (addr == A_DATA);
        is_master = ctl_q.en && ctl_q.mstr;
        is_slave  = ctl_q.en && !ctl_q.mstr;
        fault     = is_master && !ss_s;
        m_start   = wr_data && is_master && !busy;
        s_start   = is_slave && ss_d && !ss_s;
        eng_start = m_start || s_start;
        eng_load  = m_start ? wdata : tx_buf_q;
        eng_abort = fault || (is_slave && ss_s && busy) || (!ctl_q.en && busy);
        eng_step  = is_master ? tick : (is_slave && !ss_s && (sck_s ^ sck_d));
        eng_bit_in = is_master ? miso_i : mosi_s;
    end

    spi_rate_gen #(.CW(HALF_W)) i_rate (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && is_master),
        .lim  (half_limit(ctl_q.rate)),
        .tick (tick)
    );

    spi_shift_engine #(.DW(DATA_W)) i_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .abort   (eng_abort),
        .step    (eng_step),
        .cpha    (ctl_q.cpha),
        .bit_in  (eng_bit_in),
        .load    (eng_load),
        .busy    (busy),
        .done    (done),
        .lvl     (lvl),
        .bit_out (bit_out),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            flg_q      <= '0;
            arm_data_q <= 1'b0;
            arm_ctl_q  <= 1'b0;
            tx_buf_q   <= '0;
            rx_buf_q   <= '0;
        end else begin
            if (wr_ctrl)
                ctl_q <= ctrl_t'(wdata);
            if (wr_ctrl && arm_ctl_q) begin
                flg_q.modf <= 1'b0;
                arm_ctl_q  <= 1'b0;
            end
            if (acc_data && arm_data_q) begin
                flg_q.done <= 1'b0;
                flg_q.wcol <= 1'b0;
                arm_data_q <= 1'b0;
            end
            if (rd_stat) begin
                arm_data_q <= 1'b1;
                arm_ctl_q  <= 1'b1;
            end
            if (fault) begin
                ctl_q.en   <= 1'b0;
                ctl_q.mstr <= 1'b0;
                flg_q.modf <= 1'b1;
            end
            if (done) begin
                flg_q.done <= 1'b1;
                rx_buf_q   <= rx_word;
            end
            if (wr_data && busy)
                flg_q.wcol <= 1'b1;
            if (wr_data && !busy)
                tx_buf_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && rd_en) begin
            case (addr)
                A_CTRL:  rdata = ctl_q;
                A_STAT:  rdata = stat_word(flg_q);
                A_DATA:  rdata = rx_buf_q;
                default: rdata = '0;
            endcase
        end
    end

    assign irq     = ctl_q.ie && (flg_q.done || flg_q.modf);
    assign sck_o   = ctl_q.cpol ^ lvl;
    assign sck_oe  = is_master;
    assign mosi_o  = bit_out;
    assign mosi_oe = is_master;
    assign miso_o  = bit_out;
    assign miso_oe = is_slave && !ss_s;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input ctrl_t ctl,
    input logic  ss_s,
    input logic  busy,
    input logic  done,
    input logic  spif,
    input logic  wcol,
    input logic  modf,
    input logic  wr_data,
    input logic  sck_o,
    input logic  miso_oe
);
    p_done_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> spif);

    p_sck_rests_at_cpol_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.mstr && !busy) |-> (sck_o == ctl.cpol));

    p_collision_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> wcol);

    p_miso_released_r8: assert property (@(posedge clk) disable iff (rst)
        ss_s |-> !miso_oe);

    p_mode_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.mstr && !ss_s) |=> (modf && !ctl.en && !ctl.mstr));
endmodule

bind spi_port spi_port_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl_q),
    .ss_s    (ss_s),
    .busy    (busy),
    .done    (done),
    .spif    (flg_q.done),
    .wcol    (flg_q.wcol),
    .modf    (flg_q.modf),
    .wr_data (wr_data),
    .sck_o   (sck_o),
    .miso_oe (miso_oe)
);

// File: tb/test_spi_port.sv
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       ss_n = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    localparam int H = 6;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_port i_spi_port (
        .clk(clk), .rst(rst), .sel(sel), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .ss_n(ss_n), .sck_i(sck_i),
        .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [1:0] rate);
        case (rate)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1'b1; rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] srx,
                               input logic [1:0] rate, input logic cpol,
                               input logic cpha, input bit mid_wr);
        logic [7:0] got = 8'h00;
        logic [7:0] v;
        logic       prev;
        int e = 0, sidx, t0 = 0, t1 = 0, guard = 0;
        ss_n = 1'b1;
        wr(2'd0, {1'b1, 1'b1, 1'b0, 1'b1, cpol, cpha, rate});
        @(negedge clk);
        chk("R3 sck idle level", sck_o, cpol);
        chk("R8 master pin enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        if (!cpha) begin miso_i = srx[7]; sidx = 6; end else sidx = 7;
        prev = sck_o;
        sel = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = tx;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0;
        while (e < 16 && guard < 4000) begin
            if (sck_o != prev) begin
                if (e == 0) t0 = cyc;
                if (e == 1) t1 = cyc;
                if (((e % 2) == 0) ^ cpha) got = {got[6:0], mosi_o};
                else if (sidx >= 0) begin miso_i = srx[sidx]; sidx--; end
                e++;
                prev = sck_o;
                if (mid_wr && e == 4) wr(2'd2, ~tx);
            end
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        chk("R3 sck back to idle", sck_o, cpol);
        chk("R10 irq on done", irq, 1);
        chk("R1 sck half period", t1 - t0, exp_half(rate));
        chk("R2 mosi byte", got, tx);
        if (mid_wr) chk("R7 mosi byte kept under collision", got, tx);
        rd(2'd1, v);
        chk(mid_wr ? "R7 status with collision" : "R2 status done", v, mid_wr ? 8'hC0 : 8'h80);
        rd(2'd2, v);
        chk("R2 received byte", v, srx);
        rd(2'd1, v);
        chk("R11 done and collision cleared", v, 8'h00);
    endtask

    task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                              input logic cpol, input logic cpha,
                              input int nedges, input bit mid);
        logic [7:0] got = 8'h00;
        logic [7:0] v, prev_rx;
        int mi;
        ss_n = 1'b1; sck_i = cpol; mosi_i = 1'b0;
        wr(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, cpol, cpha, 2'b00});
        wr(2'd2, stx);
        rd(2'd2, prev_rx);
        repeat (4) @(negedge clk);
        if (!cpha) begin mosi_i = mtx[7]; mi = 6; end else mi = 7;
        ss_n = 1'b0;
        repeat (H) @(negedge clk);
        chk("R8 miso driven when selected", miso_oe, 1);
        if (!cpha) chk("R5 first bit before any edge", miso_o, stx[7]);
        for (int e = 0; e < nedges; e++) begin
            bit samp;
            samp = ((e % 2) == 0) ^ cpha;
            if (samp) got = {got[6:0], miso_o};
            sck_i = ~sck_i;
            if (!samp && mi >= 0) begin mosi_i = mtx[mi]; mi--; end
            if (mid && e == 5) begin
                rd(2'd2, v);
                chk("R6 read during transfer gives old byte", v, prev_rx);
                wr(2'd2, 8'h3C);
                repeat (H - 4) @(negedge clk);
            end else begin
                repeat (H) @(negedge clk);
            end
        end
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 miso released after deselect", miso_oe, 0);
        if (nedges == 16) begin
            chk(mid ? "R6 miso byte kept under collision" : "R5 miso byte", got, stx);
            rd(2'd1, v);
            chk(mid ? "R6 status with collision" : "R4 status done", v, mid ? 8'hC0 : 8'h80);
            rd(2'd2, v);
            chk("R4 slave received byte", v, mtx);
        end else begin
            rd(2'd1, v);
            chk("R4 early release leaves done clear", v[7], 0);
            rd(2'd2, v);
            chk("R4 early release keeps old byte", v, prev_rx);
        end
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] v;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state and register map
        rd(2'd0, v); chk("R12 control after reset", v, 8'h00);
        rd(2'd1, v); chk("R12 status after reset", v, 8'h00);
        chk("R12 pins off after reset", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);
        wr(2'd0, 8'h2B);
        rd(2'd0, v); chk("R12 control readback", v, 8'h2B);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        rd(2'd0, v); chk("R12 write without select ignored", v, 8'h2B);
        rd(2'd3, v); chk("R12 address 3 reads zero", v, 8'h00);

        // R1 every rate code, mode 0
        for (int r = 0; r < 4; r++)
            master_xfer(8'hA5 ^ 8'(r), 8'h3C + 8'(r), 2'(r), 1'b0, 1'b0, 1'b0);
        // R3 all four clock modes
        for (int m = 0; m < 4; m++)
            master_xfer(8'h96, 8'h5A, 2'd1, m[1], m[0], 1'b0);
        // R7 collision in master mode
        master_xfer(8'hC3, 8'h18, 2'd3, 1'b0, 1'b1, 1'b1);
        // random master traffic
        for (int i = 0; i < 8; i++) begin
            int unsigned rv = $urandom();
            master_xfer(8'(rv), 8'(rv >> 8), 2'(rv >> 16), rv[18], rv[19], 1'b0);
        end

        // R4/R5 slave transfers in all modes
        for (int m = 0; m < 4; m++)
            slave_xfer(8'h6D + 8'(m), 8'hB1 ^ 8'(m << 2), m[1], m[0], 16, 1'b0);
        // R4 early SS release
        slave_xfer(8'hF0, 8'h0F, 1'b0, 1'b0, 10, 1'b0);
        // R6 access during slave transfer
        slave_xfer(8'h81, 8'hE7, 1'b1, 1'b1, 16, 1'b1);
        slave_xfer(8'h42, 8'h99, 1'b0, 1'b0, 16, 1'b1);
        for (int i = 0; i < 4; i++) begin
            int unsigned rv = $urandom();
            slave_xfer(8'(rv), 8'(rv >> 8), rv[16], rv[17], 16, 1'b0);
        end

        // R8 deselected slave ignores SCK and MOSI
        wr(2'd0, 8'h40);
        rd(2'd2, v);
        ss_n = 1'b1;
        for (int e = 0; e < 16; e++) begin
            sck_i = ~sck_i; mosi_i = ~mosi_i;
            repeat (H) @(negedge clk);
        end
        chk("R8 deselected miso off", miso_oe, 0);
        begin
            logic [7:0] s, d2;
            rd(2'd1, s); chk("R8 deselected no done", s[7], 0);
            rd(2'd2, d2); chk("R8 deselected data unchanged", d2, v);
        end

        // R9 mode fault, R10 irq, R11 clearing order
        ss_n = 1'b1;
        wr(2'd0, 8'hD0);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 pins released on fault", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        rd(2'd0, v); chk("R9 master and enable cleared", v & 8'h50, 8'h00);
        chk("R10 irq on mode fault", irq, 1);
        wr(2'd0, 8'h80);
        rd(2'd1, v); chk("R11 fault kept without status read", v, 8'h10);
        chk("R10 irq still high", irq, 1);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R11 fault cleared", v, 8'h00);
        chk("R10 irq low", irq, 0);
        ss_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule